// File: doc/BRIEF.md
# Selectable Cascaded Half-Band Decimator

This block takes a signed 16-bit sample stream that arrives one word per clock from a converter front end and reduces its rate through three cascaded 2:1 half-band FIR stages. The stages always run. A two-bit mode input picks which point of the chain reaches the output register: the raw front-end word, or the output of the first, second or third stage. The overall decimation is therefore 1, 2, 4 or 8. The output is a 16-bit two's complement word together with a data-available strobe that pulses once per output sample and an out-of-range flag for that sample.

Each stage is linear phase. Its coefficients are symmetric, and apart from the centre tap every even offset from the centre is zero. Each stage folds mirrored samples before multiplying, so only the nonzero coefficients need a multiplier. The coefficients come from a parameterised formula rather than a stored table. A synchronous reset also acts as the sync input: it clears all filter history and restarts the decimation phase. Several instances released from reset on the same edge therefore strobe on the same edges.

Top module: `hbdec_top`

## Requirements
- R1: The mode input selects the overall decimation: 0 bypass (÷1), 1 gives ÷2, 2 gives ÷4, 3 gives ÷8. While the mode is held, consecutive `dav` pulses are exactly that many clocks apart.
- R2: In mode 0, every clock after reset `dav` is high and `dout` equals the `fe_dat` captured at the previous edge.
- R3: A stage of N taps emits output m from its input sequence x as sum over j of h[j]·x[2m+1−j], with x taken as zero before reset release. The sum is rounded by adding 16384 and shifting right arithmetically by 15.
- R4: Coefficients, in units of 2^-15: the centre tap (offset 0) is 16384 and every nonzero even offset is 0. Odd offset 2k+1 is (−1)^k·floor(10430·(M−k)/(M·(2k+1))), where M=(N+1)/4. Stage lengths are 23, 11 and 107 taps.
- R5: A rounded result above 32767 or below −32768 is clamped to that limit. The out-of-range flag is set for that output sample only.
- R6: `fe_ovr`, or an overflow in any earlier stage, that occurs among the inputs feeding an output sample sets `otr` for that sample. In mode 0, `otr` follows `fe_ovr` of the same sample.
- R7: While `srst` is high, `dav`, `dout` and `otr` are 0 and all history is cleared. Counting the first edge with `srst` low as edge 0, the first `dav` appears after edge 0, 2, 5 or 10 for modes 0, 1, 2 and 3.
- R8: Output samples in modes 1 to 3 are the first, second and third stage outputs of the cascade. Each stage consumes the previous stage's outputs in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one front-end sample per rising edge |
| srst | input | 1 | Synchronous active-high reset and phase sync |
| mode | input | 2 | Decimation select: 0 ÷1, 1 ÷2, 2 ÷4, 3 ÷8 |
| fe_dat | input | 16 | Front-end sample, two's complement |
| fe_ovr | input | 1 | Front-end overrange marker for this sample |
| dout | output | 16 | Output sample, two's complement |
| dav | output | 1 | One-clock strobe marking a new output sample |
| otr | output | 1 | Out-of-range flag for the current output sample |

## Verification
A single impulse traces the composite impulse response of each mode and shows whether the tap positions, the signs and the folding pairs are right. A sinusoid and a seeded random stream with sparse front-end overrange marks exercise full-rate rounding and the propagation of the overrange mark through the cascade. A full-scale DC step, positive and then negative, drives the first stage past its unity-gain limit. It separates clamping and the per-sample flag from plain wraparound. Every run starts from reset, so it also checks the first-strobe edge and the strobe spacing for each mode.

// File: rtl/hbdec_pkg.sv
package hbdec_pkg;

    localparam int SW = 16;          // sample width
    localparam int CF = 15;          // coefficient fraction bits
    localparam int CENTRE = 1 << (CF - 1);
    localparam int SINC_K = 10430;   // 2^15 / pi, rounded

    typedef logic signed [SW-1:0] samp_t;

    typedef enum logic [1:0] {
        DEC_BYPASS = 2'd0,
        DEC_X2     = 2'd1,
        DEC_X4     = 2'd2,
        DEC_X8     = 2'd3
    } dec_mode_e;

    typedef struct packed {
        logic  vld;
        logic  ovf;
        samp_t dat;
    } hb_bus_t;

    // Odd-offset half-band coefficient: tapered sinc, alternating sign
    function automatic int hb_coef(input int k, input int m);
        int mag;
        mag = (SINC_K * (m - k)) / (m * (2 * k + 1));
        return (k % 2 == 1) ? -mag : mag;
    endfunction

endpackage

// File: rtl/hb_stage.sv
module hb_stage
    import hbdec_pkg::*;
#(
    parameter int NTAP = 23
) (
    input  logic    clk,
    input  logic    srst,
    input  hb_bus_t in_b,
    output hb_bus_t out_b
);
    localparam int M  = (NTAP + 1) / 4;
    localparam int C  = (NTAP - 1) / 2;
    localparam int AW = SW + CF + 8;
    localparam logic signed [AW-1:0] CTR_V = AW'(CENTRE);
    localparam logic signed [AW-1:0] HALF  = AW'(2 ** (CF - 1));
    localparam logic signed [AW-1:0] MAXV  = AW'(2 ** (SW - 1) - 1);
    localparam logic signed [AW-1:0] MINV  = -(AW'(2 ** (SW - 1)));

    samp_t hist [NTAP-1];
    samp_t win  [NTAP];
    logic  phase;
    logic  stk;
    logic signed [AW-1:0] terms [M];
    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] rnd;
    samp_t sat_dat;
    logic  sat_hit;

    always_comb begin
        win[0] = in_b.dat;
        for (int j = 1; j < NTAP; j++) win[j] = hist[j-1];
    end

    // fold mirrored samples, one multiplier per nonzero coefficient
    for (genvar k = 0; k < M; k++) begin : g_pair
        localparam int LO = C - 2 * k - 1;
        localparam int HI = C + 2 * k + 1;
        localparam logic signed [AW-1:0] CKV = AW'(hb_coef(k, M));
        assign terms[k] = CKV * (AW'(win[LO]) + AW'(win[HI]));
    end

    always_comb begin
        acc = CTR_V * AW'(win[C]);
        for (int k = 0; k < M; k++) acc = acc + terms[k];
        rnd = (acc + HALF) >>> CF;
        sat_hit = 1'b0;
        if (rnd > MAXV) begin
            sat_dat = MAXV[SW-1:0];
            sat_hit = 1'b1;
        end else if (rnd < MINV) begin
            sat_dat = MINV[SW-1:0];
            sat_hit = 1'b1;
        end else begin
            sat_dat = rnd[SW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            for (int j = 0; j < NTAP - 1; j++) hist[j] <= '0;
            phase <= 1'b0;
            stk   <= 1'b0;
            out_b <= '0;
        end else begin
            out_b.vld <= 1'b0;
            if (in_b.vld) begin
                hist[0] <= in_b.dat;
                for (int j = 1; j < NTAP - 1; j++) hist[j] <= hist[j-1];
                phase <= ~phase;
                if (!phase) begin
                    stk <= in_b.ovf;
                end else begin
                    out_b.vld <= 1'b1;
                    out_b.dat <= sat_dat;
                    out_b.ovf <= stk | in_b.ovf | sat_hit;
                end
            end
        end
    end

    AST_OUT_ALT: assert property (@(posedge clk) disable iff (srst)
        out_b.vld |=> !out_b.vld);                                  // R1
    AST_OVF_CARRY: assert property (@(posedge clk) disable iff (srst)
        (in_b.vld && in_b.ovf && phase) |=> (out_b.vld && out_b.ovf)); // R6
    AST_SAT_FLAG: assert property (@(posedge clk) disable iff (srst)
        (in_b.vld && phase && sat_hit) |=> out_b.ovf);              // R5

endmodule

// File: rtl/hbdec_top.sv
module hbdec_top
    import hbdec_pkg::*;
#(
    parameter int TAPS_S1 = 23,
    parameter int TAPS_S2 = 11,
    parameter int TAPS_S3 = 107
) (
    input  logic        clk,
    input  logic        srst,
    input  logic [1:0]  mode,
    input  logic [15:0] fe_dat,
    input  logic        fe_ovr,
    output logic [15:0] dout,
    output logic        dav,
    output logic        otr
);
    localparam int NST = 3;
    localparam int STAGE_TAPS [NST] = '{TAPS_S1, TAPS_S2, TAPS_S3};

    hb_bus_t   link [NST+1];
    hb_bus_t   sel;
    dec_mode_e sel_mode;

    assign link[0] = '{vld: 1'b1, ovf: fe_ovr, dat: samp_t'(fe_dat)};

    for (genvar g = 0; g < NST; g++) begin : g_stage
        hb_stage #(.NTAP(STAGE_TAPS[g])) stage_i (
            .clk  (clk),
            .srst (srst),
            .in_b (link[g]),
            .out_b(link[g+1])
        );
    end

    assign sel_mode = dec_mode_e'(mode);

    always_comb begin
        unique case (sel_mode)
            DEC_BYPASS: sel = link[0];
            DEC_X2:     sel = link[1];
            DEC_X4:     sel = link[2];
            default:    sel = link[3];
        endcase
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            dav  <= 1'b0;
            dout <= '0;
            otr  <= 1'b0;
        end else begin
            dav <= sel.vld;
            if (sel.vld) begin
                dout <= sel.dat;
                otr  <= sel.ovf;
            end
        end
    end

    AST_BYPASS_DATA: assert property (@(posedge clk) disable iff (srst)
        ($past(mode) == 2'd0 && !$past(srst)) |-> (dav && dout == $past(fe_dat))); // R2
    AST_BYPASS_OTR: assert property (@(posedge clk) disable iff (srst)
        ($past(mode) == 2'd0 && !$past(srst)) |-> (otr == $past(fe_ovr)));         // R6
    AST_DAV_GAP: assert property (@(posedge clk) disable iff (srst)
        (dav && mode != 2'd0) |=> (!dav || mode != $past(mode)));                  // R1
    AST_RST_QUIET: assert property (@(posedge clk) disable iff (srst)
        $past(srst) |-> !dav);                                                     // R7

endmodule

// File: tb/hbdec_top_tb_top.sv
module hbdec_top_tb_top;

    localparam int L = 1040;

    logic        clk = 1'b0;
    logic        srst = 1'b1;
    logic [1:0]  mode = 2'd0;
    logic [15:0] fe_dat = '0;
    logic        fe_ovr = 1'b0;
    logic [15:0] dout;
    logic        dav;
    logic        otr;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int sig [4][L];
    bit ov  [4][L];
    int got_d [L];
    bit got_o [L];
    int got_e [L];
    int ncap;

    hbdec_top dut_i (
        .clk(clk), .srst(srst), .mode(mode), .fe_dat(fe_dat),
        .fe_ovr(fe_ovr), .dout(dout), .dav(dav), .otr(otr)
    );

    always #5 clk = ~clk;

    function automatic int tb_coef(input int ntap, input int j);
        int c, d, k, m, mag;
        c = (ntap - 1) / 2;
        d = (j > c) ? j - c : c - j;
        m = (ntap + 1) / 4;
        if (d == 0) return 16384;
        if (d % 2 == 0) return 0;
        k = (d - 1) / 2;
        mag = (10430 * (m - k)) / (m * (2 * k + 1));
        return (k % 2 == 1) ? -mag : mag;
    endfunction

    task automatic ref_stage(input int s, input int ntap, input int nin);
        for (int m = 0; m < nin / 2; m++) begin
            longint acc = 0;
            longint r;
            bit hit = 0;
            for (int j = 0; j < ntap; j++) begin
                int idx = 2 * m + 1 - j;
                if (idx >= 0) acc += longint'(tb_coef(ntap, j)) * sig[s][idx];
            end
            r = (acc + 16384) >>> 15;
            if (r > 32767) begin r = 32767; hit = 1; end
            if (r < -32768) begin r = -32768; hit = 1; end
            sig[s+1][m] = int'(r);
            ov[s+1][m] = ov[s][2*m] | ov[s][2*m+1] | hit;
        end
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input int md, input int pat);
        int fac;
        int first_exp [4] = '{0, 2, 5, 10};
        int nsat = 0;
        fac = 1 << md;
        for (int k = 0; k < L; k++) begin
            int v = 0;
            bit o = 0;
            case (pat)
                0: v = (k == 40) ? 16000 : 0;
                1: v = $rtoi(20000.0 * $sin(2.0 * 3.14159265 * k / 37.0));
                2: begin
                    v = int'($urandom % 65536) - 32768;
                    o = ($urandom % 50) == 0;
                end
                default: v = (k < L/4) ? 32767 : (k < L/2) ? 0 : (k < 3*L/4) ? -32768 : 0;
            endcase
            sig[0][k] = v;
            ov[0][k] = o;
        end
        ref_stage(0, 23, L);
        ref_stage(1, 11, L / 2);
        ref_stage(2, 107, L / 4);

        srst = 1'b1;
        mode = 2'(md);
        repeat (3) @(negedge clk);
        // R7: reset state
        check(dav == 0 && dout == 0 && otr == 0, "R7 reset state", int'(dav), 0);
        ncap = 0;
        for (int k = 0; k <= L; k++) begin
            if (k > 0 && dav) begin
                got_d[ncap] = int'($signed(dout));
                got_o[ncap] = otr;
                got_e[ncap] = k - 1;
                ncap++;
            end
            if (k < L) begin
                fe_dat = 16'(sig[0][k]);
                fe_ovr = ov[0][k];
                srst = 1'b0;
            end
            @(negedge clk);
        end
        srst = 1'b1;

        check(ncap >= L / fac - 3, "R1 strobe count", ncap, L / fac);
        if (ncap > 0)
            check(got_e[0] == first_exp[md], "R7 first strobe edge", got_e[0], first_exp[md]);
        for (int i = 0; i < ncap && i < L / fac; i++) begin
            // R2 (mode 0), R3 R4 R8 (modes 1..3)
            check(got_d[i] == sig[md][i], md == 0 ? "R2 bypass data" : "R3 R4 R8 filtered data",
                  got_d[i], sig[md][i]);
            // R5 R6
            check(got_o[i] == ov[md][i], "R5 R6 out-of-range flag", int'(got_o[i]), int'(ov[md][i]));
            if (got_o[i] && (got_d[i] == 32767 || got_d[i] == -32768)) nsat++;
            if (i > 0)
                check(got_e[i] - got_e[i-1] == fac, "R1 strobe spacing", got_e[i] - got_e[i-1], fac);
        end
        if (pat == 3 && md == 1)
            check(nsat > 0, "R5 full-scale DC clamps", nsat, 1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int md = 0; md < 4; md++)
            for (int pat = 0; pat < 4; pat++)
                run(md, pat);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule